// File: doc/BRIEF.md
# E1 Transmit Formatter with HDB3 Line Coding

This block takes one bit of serial transmit data per clock and produces the two bipolar line rails for a 2048 kbit/s E1 link. A pulse on the frame sync input marks the first bit of a frame. From that point the block counts 256-bit frames by itself. In every frame it replaces bits 2 to 8 of time slot 0 with a fixed word. Frames alternate between alignment content and non-alignment content. The first bit of time slot 0, the international bit, still comes from the serial input.

An alarm input forces every bit to one, which makes the line carry the all-ones alarm pattern. The resulting bit stream is line coded with alternate mark inversion. Optional HDB3 substitution replaces runs of four zeros. A four-stage delay line holds the bits until the coder knows whether a run must be replaced. Each bit therefore reaches the rails four clocks after it is sampled, whether substitution is on or off.

CRC-4, channel-associated signalling and the analog driver are outside this block. Signalling must already be present in time slot 16 of the serial input.

Top module: `e1_tx_formatter`

## Requirements
- R1: While reset is asserted, both rails are low. After reset, the first mark leaves on the positive rail, and the count of pulses since the last violation starts at zero, which is even.
- R2: A bit sampled on clock edge n reaches the rails on edge n+4. A space drives both rails low. Without substitution, successive marks alternate between the positive and negative rail.
- R3: The bit sampled with the sync input high is the international bit, bit 1 of time slot 0, of an alignment frame. Before the first sync pulse, data passes through with no time slot 0 overwrite.
- R4: In an alignment frame, bits 2 to 8 of time slot 0 are sent in time order as 0,0,1,1,0,1,1.
- R5: In a non-alignment frame, bit 2 of time slot 0 is 1, and bits 3 to 8 (the remote alarm bit and the five spare bits) are 0.
- R6: Bit 1 of time slot 0 is always the serial input bit, in both frame types.
- R7: With no further sync pulse, the framing free-runs with a 256-bit period and alternates frame types. A later sync pulse restarts the framing at an alignment frame, even in the middle of a frame.
- R8: A bit sampled with the alarm input high is sent as a one. This overrides both the serial data and the time slot 0 overwrite.
- R9: With the HDB3 enable high when the fourth zero of an unsubstituted run of four zeros is sampled, the run is replaced by B00V. B00V is used if the number of pulses since the last violation is even, and 000V if that number is odd.
- R10: A violation pulse has the same polarity as the pulse before it. A B pulse follows normal alternation. With the enable low, zeros are never substituted.
- R11: The two rails are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_i | input | 1 | Serial transmit data, one bit per clock |
| sync_i | input | 1 | Frame start pulse, marks bit 1 of time slot 0 |
| ais_i | input | 1 | Force all-ones alarm pattern |
| hdb3_en_i | input | 1 | Enable four-zero substitution |
| pos_o | output | 1 | Positive rail pulse |
| neg_o | output | 1 | Negative rail pulse |

## Verification
The bench tracks the violation parity across mixed runs of zeros. A coder that mixes up the even and odd cases would send 000V where B00V belongs and would break the polarity balance. Runs longer than four zeros, and runs that start inside the reset state of the delay line, show whether a consumed zero is reused in a second substitution.

The bench checks frame wrap without sync and a resync in the middle of a frame. An off-by-one counter would place the alignment word one bit late, and a missed resync would keep the old phase. Alarm windows that cover time slot 0 catch an overwrite that wrongly takes priority over the all-ones pattern. Toggling the enable in the middle of the stream tests that the enable is sampled when the fourth zero arrives.

// File: rtl/e1_tx_pkg.sv
package e1_tx_pkg;
  localparam int unsigned FRAME_BITS = 256;
  localparam int unsigned TS0_BITS   = 8;
  localparam int unsigned SUB_DEPTH  = 4;
  localparam int unsigned TS0_IDX_W  = $clog2(TS0_BITS);
  // index 7-pos gives bit for position pos (pos 0 is Si, unused here)
  localparam logic [TS0_BITS-1:0] FAS_BYTE  = 8'h1B;
  localparam logic [TS0_BITS-1:0] NFAS_BYTE = 8'h40;

  typedef enum logic [1:0] {TAG_NONE, TAG_B, TAG_V} sub_tag_e;

  typedef struct packed {
    logic     mark;
    sub_tag_e tag;
  } stage_t;
endpackage

// File: rtl/e1_frame_timer.sv
module e1_frame_timer
  import e1_tx_pkg::*;
#(
  parameter int unsigned FRAME_LEN = FRAME_BITS,
  localparam int unsigned CNT_W = $clog2(FRAME_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  output logic [CNT_W-1:0] pos_o,
  output logic             odd_o,
  output logic             locked_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             odd_q, locked_q;

  // sync bit is position 0 of an alignment frame
  assign pos_o    = sync_i ? '0 : cnt_q;
  assign odd_o    = sync_i ? 1'b0 : odd_q;
  assign locked_o = sync_i | locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      odd_q    <= 1'b0;
      locked_q <= 1'b0;
    end else if (sync_i) begin
      cnt_q    <= CNT_W'(1);
      odd_q    <= 1'b0;
      locked_q <= 1'b1;
    end else if (locked_q) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        odd_q <= ~odd_q;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // R3
  sync_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> (cnt_q == CNT_W'(1)) && !odd_q && locked_q);

  // R7
  frame_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_q && !sync_i && cnt_q == LAST) |=> (cnt_q == '0) && (odd_q != $past(odd_q)));
endmodule

// File: rtl/e1_ts0_insert.sv
module e1_ts0_insert
  import e1_tx_pkg::*;
#(
  parameter int unsigned CNT_W = $clog2(FRAME_BITS)
) (
  input  logic             ser_i,
  input  logic             ais_i,
  input  logic             locked_i,
  input  logic [CNT_W-1:0] pos_i,
  input  logic             odd_i,
  output logic             bit_o
);
  logic                 in_ts0;
  logic [TS0_IDX_W-1:0] sel;
  logic [TS0_BITS-1:0]  word;

  assign in_ts0 = locked_i && (pos_i < CNT_W'(TS0_BITS)) && (pos_i != '0);
  assign sel    = TS0_IDX_W'(TS0_BITS - 1) - TS0_IDX_W'(pos_i);
  assign word   = odd_i ? NFAS_BYTE : FAS_BYTE;

  always_comb begin
    bit_o = ser_i;
    if (in_ts0) bit_o = word[sel];
    if (ais_i)  bit_o = 1'b1;   // alarm wins over everything
  end
endmodule

// File: rtl/e1_hdb3_coder.sv
module e1_hdb3_coder
  import e1_tx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic hdb3_en_i,
  output logic pos_o,
  output logic neg_o
);
  localparam int unsigned D = SUB_DEPTH;

  stage_t st_q [D];
  stage_t st_d [D];
  stage_t lv;
  logic   par_q, par_eff, last_neg_q, win_zero, sub, emit, pol_neg;

  assign lv = st_q[D-1];

  always_comb begin
    win_zero = !bit_i;
    for (int k = 0; k < D-1; k++)
      win_zero &= !st_q[k].mark && (st_q[k].tag == TAG_NONE);
    sub = hdb3_en_i && win_zero;

    // pulse parity since last violation, including the bit now leaving
    if (lv.tag == TAG_V) par_eff = 1'b0;
    else                 par_eff = par_q ^ (lv.mark || lv.tag == TAG_B);

    st_d[0] = '{mark: bit_i, tag: sub ? TAG_V : TAG_NONE};
    for (int k = 1; k < D; k++) st_d[k] = st_q[k-1];
    if (sub && !par_eff) st_d[D-1].tag = TAG_B;

    emit    = lv.mark || (lv.tag != TAG_NONE);
    pol_neg = (lv.tag == TAG_V) ? last_neg_q : ~last_neg_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < D; k++) st_q[k] <= '{mark: 1'b0, tag: TAG_NONE};
      par_q      <= 1'b0;
      last_neg_q <= 1'b1;   // first mark goes positive
      pos_o      <= 1'b0;
      neg_o      <= 1'b0;
    end else begin
      for (int k = 0; k < D; k++) st_q[k] <= st_d[k];
      par_q <= par_eff;
      if (emit) last_neg_q <= pol_neg;
      pos_o <= emit && !pol_neg;
      neg_o <= emit && pol_neg;
    end
  end

  // R2
  space_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lv.mark && lv.tag == TAG_NONE) |=> (!pos_o && !neg_o));
endmodule

// File: rtl/e1_tx_formatter.sv
module e1_tx_formatter
  import e1_tx_pkg::*;
#(
  parameter int unsigned FRAME_LEN = FRAME_BITS,
  localparam int unsigned CNT_W = $clog2(FRAME_LEN)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ser_i,
  input  logic sync_i,
  input  logic ais_i,
  input  logic hdb3_en_i,
  output logic pos_o,
  output logic neg_o
);
  logic [CNT_W-1:0] fpos;
  logic             fodd, flocked, fbit;

  e1_frame_timer #(.FRAME_LEN(FRAME_LEN)) u_timer (
    .clk_i, .rst_ni, .sync_i,
    .pos_o(fpos), .odd_o(fodd), .locked_o(flocked)
  );

  e1_ts0_insert #(.CNT_W(CNT_W)) u_ins (
    .ser_i, .ais_i, .locked_i(flocked), .pos_i(fpos), .odd_i(fodd), .bit_o(fbit)
  );

  e1_hdb3_coder u_coder (
    .clk_i, .rst_ni, .bit_i(fbit), .hdb3_en_i, .pos_o, .neg_o
  );

  logic [2:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           age_q <= '0;
    else if (age_q != 3'd7) age_q <= age_q + 3'd1;
  end

  // R11
  rails_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pos_o && neg_o));

  // R8
  ais_mark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 3'd5 && $past(ais_i, 4)) |=> (pos_o || neg_o));
endmodule

// File: tb/e1_tx_formatter_bench.sv
`timescale 1ns/1ps
module e1_tx_formatter_bench;
  localparam int NT = 1800;
  localparam int NS = NT + 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ser = 0, sync = 0, ais = 0, hen = 0;
  logic pos_w, neg_w;
  always #2.5 clk = ~clk;

  e1_tx_formatter u_e1_tx_formatter (
    .clk_i(clk), .rst_ni(rst_n), .ser_i(ser), .sync_i(sync), .ais_i(ais),
    .hdb3_en_i(hen), .pos_o(pos_w), .neg_o(neg_w)
  );

  int n_run = 0, n_fail = 0;
  logic  fb [NS];
  logic  fen [NS];
  logic  xp [NS], xn [NS], op [NS], on_ [NS];
  string tg [NS];

  // frame model state
  bit m_locked = 0, m_odd = 0;
  int m_pos = 0, m_frames = 0;
  bit hen_r = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int got, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s got %0d exp %0d", req, what, got, exp);
    end
  endtask

  function automatic string phase_tag(input int n);
    if (n > 1000 && n <= 1300) return "R9";
    if (n > 1300 && n <= 1500) return "R10";
    if (n > 1500) return "R9";
    return "R2";
  endfunction

  // expected formatted bit for stimulus n, fills fb/tg at n+3
  task automatic model_step(input int n, input bit s, input bit sy, input bit a);
    bit b;
    string t;
    if (sy) begin m_locked = 1; m_pos = 0; m_odd = 0; m_frames = 0; end
    b = s;
    t = phase_tag(n);
    if (m_locked && m_pos == 0) t = sy ? "R3" : "R6";
    else if (!m_locked) t = "R3";
    if (m_locked && m_pos >= 1 && m_pos <= 7) begin
      if (m_odd) b = (m_pos == 1);
      else case (m_pos)
        1, 2, 5: b = 0;
        default: b = 1;
      endcase
      t = (m_frames >= 2) ? "R7" : (m_odd ? "R5" : "R4");
    end
    if (a) begin b = 1; t = "R8"; end
    fb[n+3] = b;
    tg[n+3] = t;
    if (m_locked) begin
      m_pos++;
      if (m_pos == 256) begin m_pos = 0; m_odd = !m_odd; m_frames++; end
    end
  endtask

  task automatic encode_all();
    bit last_neg = 1, par = 0;
    int i = 0;
    while (i < NS) begin
      if (i + 3 < NS && fen[i+3] && !fb[i] && !fb[i+1] && !fb[i+2] && !fb[i+3]) begin
        for (int k = 0; k < 4; k++) begin xp[i+k] = 0; xn[i+k] = 0; end
        if (!par) begin
          last_neg = !last_neg;
          xp[i] = !last_neg; xn[i] = last_neg;
        end
        xp[i+3] = !last_neg; xn[i+3] = last_neg;
        par = 0;
        i += 4;
      end else begin
        xp[i] = 0; xn[i] = 0;
        if (fb[i]) begin
          last_neg = !last_neg;
          xp[i] = !last_neg; xn[i] = last_neg;
          par = !par;
        end
        i++;
      end
    end
  endtask

  task automatic drive(input int n);
    int p1;
    bit s, sy, a;
    if (n > 1500 && n % 37 == 0) hen_r = !hen_r;
    sy = (n == 41) || (n == 1100);
    a  = (n >= 701 && n <= 760) || (n >= 790 && n <= 830) || (n >= 1700 && n <= 1720);
    if (n <= 40) p1 = 128;
    else if (n <= 1300) p1 = 64;
    else if (n <= 1500) p1 = 32;
    else p1 = 85;
    s = ($urandom % 256) < p1;
    if (n >= 1150 && n <= 1170) s = 0;
    if (n >= 1600 && n <= 1609) s = (n == 1600 || n == 1605);
    ser = s; sync = sy; ais = a;
    hen = (n > 40 && n <= 1300) ? 1'b1 : (n > 1500 ? hen_r : 1'b0);
    fen[n+3] = hen;
    model_step(n, s, sy, a);
  endtask

  initial begin
    #(5.0 * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    bit seen;
    void'($urandom(32'd4711));
    for (int k = 0; k < 4; k++) begin fb[k] = 0; fen[k] = 0; tg[k] = "R1"; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(pos_w == 0, "R1", "pos in reset", pos_w, 0);
    chk(neg_w == 0, "R1", "neg in reset", neg_w, 0);
    rst_n = 1'b1;
    drive(1);
    for (int k = 2; k <= NT + 1; k++) begin
      @(negedge clk);
      op[k-2] = pos_w; on_[k-2] = neg_w;
      // R11
      chk(!(pos_w && neg_w), "R11", "both rails high", 1, 0);
      if (k <= NT) drive(k);
      else begin ser = 0; sync = 0; ais = 0; hen = 0; end
    end
    for (int k = NT + 4; k < NS; k++) begin fb[k] = 0; fen[k] = 0; end
    encode_all();
    seen = 0;
    for (int i = 0; i < NT; i++) begin
      if (!seen && (op[i] || on_[i])) begin
        seen = 1;
        chk(op[i] == 1, "R1", "first mark on positive rail", int'(op[i]), 1);
      end
      n_run++;
      if (op[i] !== xp[i] || on_[i] !== xn[i]) begin
        n_fail++;
        $display("FAIL %s bit %0d rails got %b%b exp %b%b", tg[i], i - 3,
                 op[i], on_[i], xp[i], xn[i]);
      end
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule